// File: doc/BRIEF.md
# Bus Activity Monitor with Averaging Watermarks

The block watches one or more bus activity channels. Each channel turns single-cycle event pulses into a weighted count over a sampling period. The period is a programmable number of millisecond strobes. At the end of each period the channel takes the count as its sample and clears its accumulator. It then folds the sample into an exponential moving average whose window length is a power of two chosen per channel.

Each channel checks the raw sample against an upper and a lower watermark. A status flag is set only after a programmable run of consecutive breaching periods. Each channel also checks the freshly updated average against a second pair of watermarks. Every one of these four conditions has its own enable bit. Hardware clears that bit when the condition fires, so software must set it again before the condition can fire once more.

Software reaches the block through a single-cycle register port. A write is taken on the clock edge where the write strobe is high. Reads are combinational from the address. The port has no back-pressure, because every access completes in its cycle. The event inputs and the millisecond strobe are plain pulses, not streams. A level interrupt is raised while any enabled channel has a pending status flag.

Top module: `bus_activity_mon`

## Requirements
- R1: After reset the period register (address 0x004) reads 11, which gives a 12-strobe period. Every channel register reads 0 and `irq` is low.
- R2: A sampling period ends on the `tick_ms` strobe that finds the strobe counter at or above the period register value P. Each period therefore spans P+1 strobes. Writing the period register restarts the count.
- R3: While a channel is sampling, each cycle with its `evt` bit high adds the count-weight register (offset 0x18) to the accumulator. At a period end the accumulator becomes the sample and restarts from zero. An event in the closing cycle counts toward the next period.
- R4: At each period end the average becomes avg + ((sample − avg) >>> (K+1)), using signed arithmetic. K is control bits 12:10, so the window is 2^(K+1) samples; K = 6 gives 128.
- R5: Writing the initial-average register (offset 0x0C) loads the average. The average-count register (offset 0x20) reads the current average.
- R6: A period whose sample is above the upper watermark (offset 0x04) is an above-breach. When the run of above-breaches reaches A+1, with A in control bits 28:26, and control bit 30 is set, status bit 31 is set and control bit 30 is cleared.
- R7: A period whose sample is below the lower watermark (offset 0x08) is a below-breach. When the run of below-breaches reaches B+1, with B in control bits 25:23, and control bit 29 is set, status bit 30 is set and control bit 29 is cleared.
- R8: If the updated average is above the average-upper watermark (offset 0x10) and control bit 21 is set, status bit 29 is set and bit 21 is cleared. If the updated average is below the average-lower watermark (offset 0x14) and control bit 20 is set, status bit 28 is set and bit 20 is cleared.
- R9: Writing the status register (offset 0x24) clears the bits written as one and leaves the rest. Writing all ones clears it. A flag raised in the same cycle wins over the clear.
- R10: `irq` is high while any channel with control bit 31 set has a nonzero status. A channel samples only while control bits 31 and 18 are both set. Otherwise its accumulator and average do not change.
- R11: A sampling period that is not a breach restarts the run count for that watermark.
- R12: Channel c (counting from 0) occupies addresses (c+1)·0x40 plus the offsets above. A software write to the control register wins over a hardware clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle millisecond strobe |
| evt | input | NUM_CH | Per-channel event pulses |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle the assertions check four things. A period ends only on a millisecond strobe. The interrupt is never high without a pending flag. A full-ones status write empties the status in a quiet cycle. A rising consecutive-breach flag always comes with its enable bit already cleared. The bench scenarios cover the behaviour that spans many periods: the arithmetic of the moving average in both directions, the run length needed before a flag rises, the restart of the run after a quiet period, and the firing of the average watermarks. They also show that a disabled channel keeps its state while events arrive and that a disabled channel masks the interrupt.

// File: rtl/amon_pkg.sv
package amon_pkg;
  localparam int DATA_W = 32;
  localparam int OFFS_W = 6;
  localparam logic [OFFS_W-1:0] OFF_CTRL   = 6'h00;
  localparam logic [OFFS_W-1:0] OFF_UPPER  = 6'h04;
  localparam logic [OFFS_W-1:0] OFF_LOWER  = 6'h08;
  localparam logic [OFFS_W-1:0] OFF_INIT   = 6'h0C;
  localparam logic [OFFS_W-1:0] OFF_AUPPER = 6'h10;
  localparam logic [OFFS_W-1:0] OFF_ALOWER = 6'h14;
  localparam logic [OFFS_W-1:0] OFF_WEIGHT = 6'h18;
  localparam logic [OFFS_W-1:0] OFF_AVG    = 6'h20;
  localparam logic [OFFS_W-1:0] OFF_STATUS = 6'h24;
  localparam int GLB_PERIOD_OFFS = 4;
  // control bit positions
  localparam int B_EN      = 31;
  localparam int B_CABOVE  = 30;
  localparam int B_CBELOW  = 29;
  localparam int F_ANUM    = 26;
  localparam int F_BNUM    = 23;
  localparam int B_AVGUP   = 21;
  localparam int B_AVGDN   = 20;
  localparam int B_PERIOD  = 18;
  localparam int F_K       = 10;
  localparam int RUN_W     = 3;
  localparam int K_W       = 3;
  // status bit positions
  localparam int S_CUP  = 31;
  localparam int S_CLO  = 30;
  localparam int S_AUP  = 29;
  localparam int S_ALO  = 28;
endpackage

// File: rtl/amon_period_timer.sv
module amon_period_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [PER_W-1:0] per_value,
  output logic             period_end
);
  logic [PER_W-1:0] cnt_q;

  assign period_end = tick && (cnt_q >= per_value);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt_q <= '0;
    else if (period_end)   cnt_q <= '0;
    else if (tick)         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/amon_accum.sv
module amon_accum #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         evt,
  input  logic [W-1:0] weight,
  input  logic         close,
  output logic [W-1:0] sample
);
  logic [W-1:0] acc_q;
  logic [W:0]   sum;

  assign sum    = {1'b0, acc_q} + {1'b0, weight};
  assign sample = acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) acc_q <= '0;
    else if (close)     acc_q <= evt ? weight : '0;
    else if (evt)       acc_q <= sum[W] ? '1 : sum[W-1:0];
  end
endmodule

// File: rtl/amon_ewma.sv
module amon_ewma #(
  parameter int W   = 32,
  parameter int K_W = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [W-1:0]   load_val,
  input  logic           update,
  input  logic [W-1:0]   sample,
  input  logic [K_W-1:0] k,
  output logic [W-1:0]   avg,
  output logic [W-1:0]   avg_nx
);
  logic signed [W:0] diff;
  logic signed [W:0] step;
  logic signed [W:0] total;

  assign diff   = $signed({1'b0, sample}) - $signed({1'b0, avg});
  assign step   = diff >>> ({1'b0, k} + 1'b1);
  assign total  = $signed({1'b0, avg}) + step;
  assign avg_nx = total[W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)      avg <= '0;
    else if (load)   avg <= load_val;
    else if (update) avg <= avg_nx;
  end
endmodule

// File: rtl/amon_run_ctr.sv
module amon_run_ctr #(
  parameter int N_W = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step,
  input  logic           breach,
  input  logic [N_W-1:0] need_m1,
  output logic           hit
);
  logic [N_W-1:0] run_q;

  assign hit = step && breach && (run_q >= need_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else if (step) begin
      if (!breach)        run_q <= '0;
      else if (run_q != '1) run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/amon_channel.sv
module amon_channel
  import amon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              period_end,
  input  logic              evt,
  input  logic              wr_en,
  input  logic [OFFS_W-1:0] offs,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] status_q,
  output logic              irq_req
);
  logic [DATA_W-1:0] upper_q, lower_q, aup_q, alo_q, weight_q;
  logic [DATA_W-1:0] sample, avg, avg_nx;
  logic sampling, step;
  logic [1:0] breach, hit;
  logic [1:0][RUN_W-1:0] need;
  logic fire_ca, fire_cb, fire_aa, fire_ab;
  logic [DATA_W-1:0] set_mask, clr_mask, ctrl_hw;

  assign sampling = ctrl_q[B_EN] && ctrl_q[B_PERIOD];
  assign step     = period_end && sampling;

  amon_accum #(.W(DATA_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .run(sampling), .evt(evt),
    .weight(weight_q), .close(period_end), .sample(sample)
  );

  amon_ewma #(.W(DATA_W), .K_W(K_W)) u_avg (
    .clk(clk), .rst_n(rst_n),
    .load(wr_en && offs == OFF_INIT), .load_val(wdata),
    .update(step), .sample(sample), .k(ctrl_q[F_K +: K_W]),
    .avg(avg), .avg_nx(avg_nx)
  );

  assign breach[0] = sample > upper_q;
  assign breach[1] = sample < lower_q;
  assign need[0]   = ctrl_q[F_ANUM +: RUN_W];
  assign need[1]   = ctrl_q[F_BNUM +: RUN_W];

  for (genvar g = 0; g < 2; g++) begin : g_run
    amon_run_ctr #(.N_W(RUN_W)) u_run (
      .clk(clk), .rst_n(rst_n), .step(step), .breach(breach[g]),
      .need_m1(need[g]), .hit(hit[g])
    );
  end

  assign fire_ca = hit[0] && ctrl_q[B_CABOVE];
  assign fire_cb = hit[1] && ctrl_q[B_CBELOW];
  assign fire_aa = step && (avg_nx > aup_q) && ctrl_q[B_AVGUP];
  assign fire_ab = step && (avg_nx < alo_q) && ctrl_q[B_AVGDN];

  always_comb begin
    set_mask = '0;
    set_mask[S_CUP] = fire_ca;
    set_mask[S_CLO] = fire_cb;
    set_mask[S_AUP] = fire_aa;
    set_mask[S_ALO] = fire_ab;
    clr_mask = (wr_en && offs == OFF_STATUS) ? wdata : '0;
    ctrl_hw = ctrl_q;
    if (fire_ca) ctrl_hw[B_CABOVE] = 1'b0;
    if (fire_cb) ctrl_hw[B_CBELOW] = 1'b0;
    if (fire_aa) ctrl_hw[B_AVGUP]  = 1'b0;
    if (fire_ab) ctrl_hw[B_AVGDN]  = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      upper_q  <= '0;
      lower_q  <= '0;
      aup_q    <= '0;
      alo_q    <= '0;
      weight_q <= '0;
      status_q <= '0;
    end else begin
      status_q <= (status_q & ~clr_mask) | set_mask;
      if (wr_en && offs == OFF_CTRL) ctrl_q <= wdata;
      else                           ctrl_q <= ctrl_hw;
      if (wr_en) begin
        case (offs)
          OFF_UPPER:  upper_q  <= wdata;
          OFF_LOWER:  lower_q  <= wdata;
          OFF_AUPPER: aup_q    <= wdata;
          OFF_ALOWER: alo_q    <= wdata;
          OFF_WEIGHT: weight_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (offs)
      OFF_CTRL:   rd_data = ctrl_q;
      OFF_UPPER:  rd_data = upper_q;
      OFF_LOWER:  rd_data = lower_q;
      OFF_AUPPER: rd_data = aup_q;
      OFF_ALOWER: rd_data = alo_q;
      OFF_WEIGHT: rd_data = weight_q;
      OFF_AVG:    rd_data = avg;
      OFF_STATUS: rd_data = status_q;
      default:    rd_data = '0;
    endcase
  end

  assign irq_req = ctrl_q[B_EN] && (status_q != '0);
endmodule

// File: rtl/bus_activity_mon.sv
module bus_activity_mon
  import amon_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int ADDR_W     = 10,
  parameter int PER_W      = 16,
  parameter int PERIOD_DEF = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_ms,
  input  logic [NUM_CH-1:0] evt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int SLOT_W = ADDR_W - OFFS_W;
  localparam logic [PER_W-1:0] PER_RST = PER_W'(PERIOD_DEF - 1);

  logic [PER_W-1:0] period_q;
  logic period_end, per_wr;
  logic [SLOT_W-1:0] slot;
  logic [OFFS_W-1:0] offs;
  logic [NUM_CH-1:0] ch_sel, ch_irq;
  logic [NUM_CH-1:0][DATA_W-1:0] ch_rd;
  logic [NUM_CH*DATA_W-1:0] ctrl_flat, status_flat;

  assign slot   = addr[ADDR_W-1:OFFS_W];
  assign offs   = addr[OFFS_W-1:0];
  assign per_wr = wr_en && (addr == ADDR_W'(GLB_PERIOD_OFFS));

  always_ff @(posedge clk) begin
    if (!rst_n)      period_q <= PER_RST;
    else if (per_wr) period_q <= wdata[PER_W-1:0];
  end

  amon_period_timer #(.PER_W(PER_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick_ms), .restart(per_wr),
    .per_value(period_q), .period_end(period_end)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_sel[c] = (slot == SLOT_W'(c + 1));
    amon_channel u_ch (
      .clk(clk), .rst_n(rst_n), .period_end(period_end), .evt(evt[c]),
      .wr_en(wr_en && ch_sel[c]), .offs(offs), .wdata(wdata),
      .rd_data(ch_rd[c]),
      .ctrl_q(ctrl_flat[c*DATA_W +: DATA_W]),
      .status_q(status_flat[c*DATA_W +: DATA_W]),
      .irq_req(ch_irq[c])
    );
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(GLB_PERIOD_OFFS)) rdata = DATA_W'(period_q);
    for (int c = 0; c < NUM_CH; c++)
      if (ch_sel[c]) rdata = ch_rd[c];
  end

  assign irq = |ch_irq;
endmodule

// File: rtl/bus_activity_mon_chk.sv
module bus_activity_mon_chk
  import amon_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 10
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     tick_ms,
  input logic                     period_end,
  input logic                     wr_en,
  input logic [ADDR_W-1:0]        addr,
  input logic [DATA_W-1:0]        wdata,
  input logic                     irq,
  input logic [NUM_CH*DATA_W-1:0] ctrl_flat,
  input logic [NUM_CH*DATA_W-1:0] status_flat
);
  assert_period_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |-> tick_ms);

  assert_irq_has_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($countones(status_flat) > 0));

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'((c + 1) << OFFS_W);
    logic ctrl_wr;
    assign ctrl_wr = wr_en && (addr == (BASE | ADDR_W'(OFF_CTRL)));

    assert_status_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == (BASE | ADDR_W'(OFF_STATUS)) && wdata == '1 && !period_end)
      |=> (status_flat[c*DATA_W +: DATA_W] == '0));

    assert_above_disarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(status_flat[c*DATA_W + S_CUP]) && !$past(ctrl_wr))
      |-> !ctrl_flat[c*DATA_W + B_CABOVE]);

    assert_below_disarm_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(status_flat[c*DATA_W + S_CLO]) && !$past(ctrl_wr))
      |-> !ctrl_flat[c*DATA_W + B_CBELOW]);
  end
endmodule

bind bus_activity_mon bus_activity_mon_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .period_end(period_end),
  .wr_en(wr_en), .addr(addr), .wdata(wdata), .irq(irq),
  .ctrl_flat(ctrl_flat), .status_flat(status_flat)
);

// File: tb/bus_activity_mon_bench.sv
`timescale 1ns/1ps
module bus_activity_mon_bench;
  localparam int NUM_CH = 2;
  localparam int ADDR_W = 10;
  localparam logic [ADDR_W-1:0] A_PER = 10'h004;

  logic clk = 1'b0, rst_n = 1'b0, tick_ms = 1'b0, wr_en = 1'b0;
  logic [NUM_CH-1:0] evt = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;

  always #10 clk = ~clk;

  bus_activity_mon #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_bus_activity_mon (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .evt(evt), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  logic  sample_now = 1'b0;
  int    n_checks = 0, n_fail = 0;
  bit    done = 1'b0;

  // monitor: pops expected items and compares against the design
  always @(negedge clk) begin
    if (sample_now && sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sb_q.pop_front();
      act = it.is_irq ? {31'd0, irq} : rdata;
      n_checks++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
      end
    end
  end

  function automatic logic [ADDR_W-1:0] ra(input int ch, input int offs);
    return ADDR_W'(((ch + 1) << 6) + offs);
  endfunction

  function automatic logic [31:0] cw(input bit en, per, input int k, bn, an,
                                     input bit avgdn, avgup, cbel, cabv);
    logic [31:0] v;
    v = '0;
    v[31] = en; v[30] = cabv; v[29] = cbel;
    v[28:26] = an[2:0]; v[25:23] = bn[2:0];
    v[21] = avgup; v[20] = avgdn; v[18] = per; v[12:10] = k[2:0];
    return v;
  endfunction

  function automatic logic [31:0] ewma(input logic [31:0] a, s, input int k);
    longint d, r;
    d = longint'(s) - longint'(a);
    r = longint'(a) + (d >>> (k + 1));
    return r[31:0];
  endfunction

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic push_chk(input bit is_irq, input logic [ADDR_W-1:0] a,
                          input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    addr = a;
    it.is_irq = is_irq; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    sample_now = 1'b1;
    @(negedge clk); #1;
    sample_now = 1'b0;
  endtask

  task automatic rd_chk(input logic [ADDR_W-1:0] a, input logic [31:0] e,
                        input string tag);
    push_chk(1'b0, a, e, tag);
  endtask

  task automatic irq_chk(input logic e, input string tag);
    push_chk(1'b1, addr, {31'd0, e}, tag);
  endtask

  task automatic events(input int ch, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; evt[ch] = 1'b1;
      @(posedge clk); #1; evt[ch] = 1'b0;
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; tick_ms = 1'b1;
      @(posedge clk); #1; tick_ms = 1'b0;
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    rd_chk(A_PER, 32'd11, "R1 period reset");
    rd_chk(ra(0, 'h00), 32'd0, "R1 ctrl reset");
    rd_chk(ra(0, 'h24), 32'd0, "R1 status reset");
    irq_chk(1'b0, "R1 irq reset");

    // period of 3 strobes, K=0
    wr(A_PER, 32'd2);
    wr(ra(0, 'h18), 32'd5);
    wr(ra(0, 'h04), 32'd1000);
    wr(ra(0, 'h00), cw(1, 1, 0, 0, 0, 0, 0, 0, 0));
    events(0, 4);
    ticks(2);
    rd_chk(ra(0, 'h20), 32'd0, "R2 no period end after P strobes");
    ticks(1);
    a = ewma(32'd0, 32'd20, 0);
    rd_chk(ra(0, 'h20), a, "R3 weighted sample folded in");
    ticks(3);
    a = ewma(a, 32'd0, 0);
    rd_chk(ra(0, 'h20), a, "R3 accumulator restarted");

    // initial average load, K=1 window, disabled channel 1
    wr(ra(0, 'h0C), 32'd100);
    rd_chk(ra(0, 'h20), 32'd100, "R5 initial average load");
    wr(ra(0, 'h00), cw(1, 1, 1, 0, 0, 0, 0, 0, 0));
    wr(ra(1, 'h0C), 32'd7);
    wr(ra(1, 'h18), 32'd5);
    events(0, 4);
    events(1, 4);
    ticks(3);
    rd_chk(ra(0, 'h20), ewma(32'd100, 32'd20, 1), "R4 downward average K=1");
    rd_chk(ra(1, 'h20), 32'd7, "R10 disabled channel keeps average");
    rd_chk(ra(1, 'h0C), 32'd0, "R12 channel 1 slot decode");

    // consecutive above: need 2 in a row
    wr(A_PER, 32'd0);
    wr(ra(0, 'h04), 32'd10);
    wr(ra(0, 'h00), cw(1, 1, 0, 0, 1, 0, 0, 0, 1));
    events(0, 3); ticks(1);
    rd_chk(ra(0, 'h24), 32'd0, "R6 single breach not enough");
    ticks(1);
    events(0, 3); ticks(1);
    rd_chk(ra(0, 'h24), 32'd0, "R11 run restarted by quiet period");
    events(0, 3); ticks(1);
    rd_chk(ra(0, 'h24), 32'h8000_0000, "R6 above flag after run");
    rd_chk(ra(0, 'h00), cw(1, 1, 0, 0, 1, 0, 0, 0, 0), "R6 above enable self-cleared");
    irq_chk(1'b1, "R10 irq with pending flag");
    wr(ra(0, 'h24), 32'hFFFF_FFFF);
    rd_chk(ra(0, 'h24), 32'd0, "R9 all-ones clear");
    irq_chk(1'b0, "R9 irq drops after clear");

    // consecutive below: need 1
    wr(ra(0, 'h08), 32'd10);
    wr(ra(0, 'h00), cw(1, 1, 0, 0, 0, 0, 0, 1, 0));
    ticks(1);
    rd_chk(ra(0, 'h24), 32'h4000_0000, "R7 below flag");
    rd_chk(ra(0, 'h00), cw(1, 1, 0, 0, 0, 0, 0, 0, 0), "R7 below enable self-cleared");
    wr(ra(0, 'h24), 32'h8000_0000);
    rd_chk(ra(0, 'h24), 32'h4000_0000, "R9 partial clear keeps other bits");
    wr(ra(0, 'h24), 32'hFFFF_FFFF);

    // average watermarks
    wr(ra(0, 'h08), 32'd0);
    wr(ra(0, 'h04), 32'd1000);
    wr(ra(0, 'h10), 32'd50);
    wr(ra(0, 'h14), 32'd0);
    wr(ra(0, 'h18), 32'd50);
    wr(ra(0, 'h0C), 32'd0);
    wr(ra(0, 'h00), cw(1, 1, 0, 0, 0, 0, 1, 0, 0));
    events(0, 4); ticks(1);
    a = ewma(32'd0, 32'd200, 0);
    rd_chk(ra(0, 'h24), 32'h2000_0000, "R8 average above flag");
    rd_chk(ra(0, 'h00), cw(1, 1, 0, 0, 0, 0, 0, 0, 0), "R8 average-above enable cleared");
    wr(ra(0, 'h24), 32'hFFFF_FFFF);
    wr(ra(0, 'h14), 32'd60);
    wr(ra(0, 'h00), cw(1, 1, 0, 0, 0, 1, 0, 0, 0));
    ticks(1);
    a = ewma(a, 32'd0, 0);
    rd_chk(ra(0, 'h24), 32'h1000_0000, "R8 average below flag");
    rd_chk(ra(0, 'h20), a, "R4 upward then downward average");

    // a disabled channel masks the interrupt
    irq_chk(1'b1, "R10 irq before disable");
    wr(ra(0, 'h00), 32'd0);
    irq_chk(1'b0, "R10 disabled channel masks irq");
    rd_chk(ra(0, 'h24), 32'h1000_0000, "R10 status kept while disabled");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule